// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits behind the bus interface of a flash memory and watches every byte write the host makes. Only a write that completes a protected unlock sequence has any effect. Program needs four writes and ends with the target address and data byte. Erase needs six writes and ends with one of three opcodes: sector, block or whole-array erase. The block then checks the target against two region-protect pins. For program it also checks that the target byte is erased. If both checks pass, it runs a timed internal operation. A cycle counter sets the length of that operation. When the count expires, the block pulses a program or erase strobe toward a behavioural array model. With the strobe it gives the latched address, data and erase kind.

Reads made while an operation runs return a status byte instead of array or register data. In that byte, bit 7 is the complement of the byte being programmed, or 0 during an erase. Bit 6 flips on each successive read. Bits 5:0 are zero. Once the operation ends, reads pass through unchanged. The write port is a valid/ready stream that never applies back-pressure: `wr_ready` is held high, and a write is taken on any cycle where `wr_valid` is high. While the block is busy, writes are taken and then discarded.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by data D at address X, raise `busy` on the clock edge that takes the fourth write. `busy` stays high for PROG_CYC cycles. It falls together with a one-cycle `prog_stb`, with `op_addr`=X and `op_data`=D. Command addresses compare only address bits 14:0.
- R2: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by 30h at X, run a sector erase. `busy` is high for ERASE_CYC cycles, then `erase_stb` pulses with `erase_kind`=0 and `op_addr`=X.
- R3: The same five-write prefix followed by 50h at X runs a block erase, with `erase_kind`=1.
- R4: The same prefix followed by 10h at 5555h runs a whole-array erase, with `erase_kind`=2. 10h at any other address starts nothing.
- R5: A write that does not match the next expected step ends the sequence. A complete new unlock sequence is then needed.
- R6: Writes taken while `busy` is high are ignored. They change neither the running operation nor its strobe values, and they start nothing afterwards.
- R7: With `top_lock_n` low, a program or sector/block erase whose address has all bits above bit 15 set (the top 64 KB) starts nothing. A whole-array erase is blocked if either protect pin is low.
- R8: With `main_lock_n` low, a program or sector/block erase outside the top 64 KB starts nothing. Each pin guards only its own region.
- R9: A program whose target byte `tgt_rdata` is not FFh starts nothing.
- R10: While `busy` is high, `rd_data` bit 7 is ~D[7] for a program and 0 for an erase, and bits 5:0 are 0. This holds for array and register reads alike. When the block is not busy, `rd_data` is `reg_rdata` if `rd_is_reg` is high, otherwise `arr_rdata`.
- R11: The first read during an operation shows bit 6 as 0. Each later read with `rd_valid` high shows the opposite value.
- R12: An asserted `rst_n` ends an operation at once: `busy` drops, and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte write request valid |
| wr_ready | output | 1 | Always high; write taken whenever valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| tgt_rdata | input | 8 | Array content at `wr_addr` (erased check) |
| top_lock_n | input | 1 | Low blocks changes to the top 64 KB |
| main_lock_n | input | 1 | Low blocks changes below the top 64 KB |
| rd_valid | input | 1 | A read is made this cycle |
| rd_is_reg | input | 1 | The read targets a register, not the array |
| arr_rdata | input | 8 | Array read data |
| reg_rdata | input | 8 | Register read data |
| rd_data | output | 8 | Read data or status byte |
| busy | output | 1 | Internal operation running |
| prog_stb | output | 1 | One-cycle program strobe at completion |
| erase_stb | output | 1 | One-cycle erase strobe at completion |
| erase_kind | output | 2 | 0 sector, 1 block, 2 whole array |
| op_addr | output | ADDR_W | Latched target address |
| op_data | output | 8 | Latched program data |

## Verification
The bench builds the block with ADDR_W=19, PROG_CYC=16 and ERASE_CYC=24. With these values, two status reads and a full six-write erase sequence both fit inside one busy window, so the toggle and the ignore-while-busy rules can be observed directly. The 19-bit address puts the top 64 KB at 70000h-7FFFFh, so both protect regions and their independence are reached with ordinary addresses. Short counts also let a reset land in the middle of an erase and the following strobe-free window be watched in full.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] UNLOCK_A = 15'h5555;
  localparam logic [CMD_AW-1:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_BLK   = 8'h50;
  localparam logic [7:0] CODE_CHIP  = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS1, ST_ERS2, ST_ERS3
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_SECTOR = 2'd0, OP_BLOCK = 2'd1, OP_CHIP = 2'd2, OP_PROG = 2'd3
  } op_kind_t;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              allow,
  output op_kind_t          cand_kind,
  output logic              start
);
  seq_state_t state, nxt;
  logic accept, at_a, at_b, final_ok;

  assign accept = wr_valid && !busy;
  assign at_a   = (cmd_addr == UNLOCK_A);
  assign at_b   = (cmd_addr == UNLOCK_B);

  always_comb begin
    nxt       = ST_IDLE;
    final_ok  = 1'b0;
    cand_kind = OP_PROG;
    case (state)
      ST_IDLE: if (wr_data == KEY_A && at_a) nxt = ST_UNL1;
      ST_UNL1: if (wr_data == KEY_B && at_b) nxt = ST_UNL2;
      ST_UNL2: begin
        if (wr_data == CODE_PROG && at_a)       nxt = ST_PGM;
        else if (wr_data == CODE_ERASE && at_a) nxt = ST_ERS1;
      end
      ST_PGM: final_ok = 1'b1;
      ST_ERS1: if (wr_data == KEY_A && at_a) nxt = ST_ERS2;
      ST_ERS2: if (wr_data == KEY_B && at_b) nxt = ST_ERS3;
      ST_ERS3: begin
        if (wr_data == CODE_SECT) begin
          final_ok = 1'b1; cand_kind = OP_SECTOR;
        end else if (wr_data == CODE_BLK) begin
          final_ok = 1'b1; cand_kind = OP_BLOCK;
        end else if (wr_data == CODE_CHIP && at_a) begin
          final_ok = 1'b1; cand_kind = OP_CHIP;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign start = accept && final_ok && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= ST_IDLE;
    else if (accept) state <= nxt;
  end

  // R6: no sequence progresses while an operation runs
  assert_idle_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state == ST_IDLE);
endmodule

// File: rtl/fcs_guard.sv
module fcs_guard
  import fcs_pkg::*;
#(
  parameter int RB_W = 3
) (
  input  op_kind_t        kind,
  input  logic [RB_W-1:0] region_bits,
  input  logic            top_lock_n,
  input  logic            main_lock_n,
  input  logic [7:0]      tgt_rdata,
  output logic            allow
);
  logic in_top, region_ok;

  assign in_top    = &region_bits;
  assign region_ok = in_top ? top_lock_n : main_lock_n;

  always_comb begin
    case (kind)
      OP_CHIP: allow = top_lock_n && main_lock_n;
      OP_PROG: allow = region_ok && (tgt_rdata == 8'hFF);
      default: allow = region_ok;
    endcase
  end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_kind_t          kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              rd_valid,
  input  logic              rd_is_reg,
  input  logic [7:0]        arr_rdata,
  input  logic [7:0]        reg_rdata,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              prog_stb,
  output logic              erase_stb,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  op_kind_t         kind_q;
  logic             tog;
  logic [7:0]       status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      kind_q    <= OP_SECTOR;
      op_addr   <= '0;
      op_data   <= '0;
      tog       <= 1'b0;
      prog_stb  <= 1'b0;
      erase_stb <= 1'b0;
    end else begin
      prog_stb  <= 1'b0;
      erase_stb <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= (kind == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
        kind_q  <= kind;
        op_addr <= addr;
        op_data <= data;
        tog     <= 1'b0;
      end else if (busy) begin
        if (rd_valid) tog <= ~tog;
        if (cnt == '0) begin
          busy <= 1'b0;
          if (kind_q == OP_PROG) prog_stb  <= 1'b1;
          else                   erase_stb <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign erase_kind = kind_q;
  assign status     = {(kind_q == OP_PROG) ? ~op_data[7] : 1'b0, tog, 6'b0};
  assign rd_data    = busy ? status : (rd_is_reg ? reg_rdata : arr_rdata);

  // R1: a strobe only closes a busy window
  assert_strobe_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || erase_stb) |-> (!busy && $past(busy)));
  // R2: every normal end of a busy window emits a strobe
  assert_fall_has_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (prog_stb || erase_stb));
  // R3: never both strobes
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, erase_stb}));
  // R10: low status bits are zero during an operation
  assert_status_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_data[5:0] == 6'd0);
  // R11: back-to-back busy reads alternate bit 6
  assert_toggle_alternates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_valid && $past(busy && rd_valid)) |-> rd_data[6] != $past(rd_data[6]));
endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int TOP_AW    = 16,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        tgt_rdata,
  input  logic              top_lock_n,
  input  logic              main_lock_n,
  input  logic              rd_valid,
  input  logic              rd_is_reg,
  input  logic [7:0]        arr_rdata,
  input  logic [7:0]        reg_rdata,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              prog_stb,
  output logic              erase_stb,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  localparam int RB_W = ADDR_W - TOP_AW;

  op_kind_t cand_kind;
  logic     allow, start;

  assign wr_ready = 1'b1;

  fcs_decode u_decode (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .cmd_addr(wr_addr[CMD_AW-1:0]), .wr_data(wr_data), .busy(busy),
    .allow(allow), .cand_kind(cand_kind), .start(start)
  );

  fcs_guard #(.RB_W(RB_W)) u_guard (
    .kind(cand_kind), .region_bits(wr_addr[ADDR_W-1:TOP_AW]),
    .top_lock_n(top_lock_n), .main_lock_n(main_lock_n),
    .tgt_rdata(tgt_rdata), .allow(allow)
  );

  fcs_timer #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(cand_kind),
    .addr(wr_addr), .data(wr_data), .rd_valid(rd_valid), .rd_is_reg(rd_is_reg),
    .arr_rdata(arr_rdata), .reg_rdata(reg_rdata), .rd_data(rd_data),
    .busy(busy), .prog_stb(prog_stb), .erase_stb(erase_stb),
    .erase_kind(erase_kind), .op_addr(op_addr), .op_data(op_data)
  );

  // R7: an operation in the top region never begins with its lock low
  assert_top_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !busy && !top_lock_n && (&wr_addr[ADDR_W-1:TOP_AW])) |=> !busy);
endmodule

// File: tb/flash_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module flash_cmd_sequencer_tb_top;
  localparam int AW = 19;
  localparam int PC = 16;
  localparam int EC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] tgt_rdata = 8'hFF;
  logic top_lock_n = 1'b1, main_lock_n = 1'b1;
  logic rd_valid = 1'b0, rd_is_reg = 1'b0;
  logic [7:0] arr_rdata = 8'h3C, reg_rdata = 8'hC5;
  logic [7:0] rd_data;
  logic busy, prog_stb, erase_stb;
  logic [1:0] erase_kind;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_sequencer #(.ADDR_W(AW), .TOP_AW(16), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .tgt_rdata(tgt_rdata),
    .top_lock_n(top_lock_n), .main_lock_n(main_lock_n),
    .rd_valid(rd_valid), .rd_is_reg(rd_is_reg), .arr_rdata(arr_rdata),
    .reg_rdata(reg_rdata), .rd_data(rd_data), .busy(busy),
    .prog_stb(prog_stb), .erase_stb(erase_stb), .erase_kind(erase_kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // op: 0 program, 1 sector, 2 block, 3 whole array
  task automatic run_seq(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
    if (op == 2'd0) begin
      wr(19'h05555, 8'hA0);
      wr(a, d);
    end else begin
      wr(19'h05555, 8'h80);
      wr(19'h05555, 8'hAA);
      wr(19'h02AAA, 8'h55);
      case (op)
        2'd1:    wr(a, 8'h30);
        2'd2:    wr(a, 8'h50);
        default: wr(a, 8'h10);
      endcase
    end
  endtask

  // {op[1:0], addr[18:0], data[7:0], top_lock_n, main_lock_n, expect_start}
  localparam logic [31:0] VEC [12] = '{
    {2'd0, 19'h01234, 8'h5A, 1'b1, 1'b1, 1'b1},
    {2'd0, 19'h7F000, 8'hC3, 1'b1, 1'b1, 1'b1},
    {2'd0, 19'h7F000, 8'hC3, 1'b0, 1'b1, 1'b0},
    {2'd0, 19'h01234, 8'h11, 1'b1, 1'b0, 1'b0},
    {2'd0, 19'h7F000, 8'h81, 1'b1, 1'b0, 1'b1},
    {2'd1, 19'h23000, 8'h00, 1'b1, 1'b1, 1'b1},
    {2'd2, 19'h40000, 8'h00, 1'b1, 1'b1, 1'b1},
    {2'd3, 19'h05555, 8'h00, 1'b1, 1'b1, 1'b1},
    {2'd3, 19'h05555, 8'h00, 1'b0, 1'b1, 1'b0},
    {2'd1, 19'h71000, 8'h00, 1'b0, 1'b1, 1'b0},
    {2'd2, 19'h10000, 8'h00, 1'b0, 1'b1, 1'b1},
    {2'd1, 19'h05000, 8'h00, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R12 reset busy", {31'd0, busy}, 32'd0);
    check("R12 reset strobes", {30'd0, prog_stb, erase_stb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle array passthrough", {24'd0, rd_data}, 32'h3C);
    rd_is_reg = 1'b1; #1;
    check("R10 idle register passthrough", {24'd0, rd_data}, 32'hC5);
    rd_is_reg = 1'b0;
    check("R1 write port ready", {31'd0, wr_ready}, 32'd1);

    for (int i = 0; i < 12; i++) begin
      logic [31:0] v;
      logic [1:0] op;
      logic [AW-1:0] a;
      logic [7:0] d;
      logic b7;
      int cyc;
      string req;
      v = VEC[i];
      op = v[31:30]; a = v[29:11]; d = v[10:3];
      top_lock_n = v[2]; main_lock_n = v[1];
      req = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : (op == 2'd2) ? "R3" : "R4";
      run_seq(op, a, d);
      if (!v[0]) begin
        check(!top_lock_n ? "R7 blocked" : "R8 blocked", {31'd0, busy}, 32'd0);
        check("R10 passthrough after drop", {24'd0, rd_data}, 32'h3C);
      end else begin
        cyc = (op == 2'd0) ? PC : EC;
        b7 = (op == 2'd0) ? ~d[7] : 1'b0;
        check({req, " busy raised"}, {31'd0, busy}, 32'd1);
        rd_valid = 1'b1; rd_is_reg = 1'b0; #1;
        check("R10 status first read", {24'd0, rd_data}, {24'd0, b7, 1'b0, 6'd0});
        @(negedge clk);
        rd_is_reg = 1'b1; #1;
        check("R11 status toggled register read", {24'd0, rd_data}, {24'd0, b7, 1'b1, 6'd0});
        rd_valid = 1'b0; rd_is_reg = 1'b0;
        repeat (cyc - 2) @(negedge clk);
        check({req, " busy last cycle"}, {31'd0, busy}, 32'd1);
        @(negedge clk);
        check({req, " busy ended"}, {31'd0, busy}, 32'd0);
        check({req, " strobe"}, {30'd0, prog_stb, erase_stb}, (op == 2'd0) ? 32'd2 : 32'd1);
        check({req, " op_addr"}, {13'd0, op_addr}, {13'd0, a});
        if (op == 2'd0) check({req, " op_data"}, {24'd0, op_data}, {24'd0, d});
        else check({req, " erase_kind"}, {30'd0, erase_kind}, {30'd0, op - 2'd1});
        check("R10 done passthrough", {24'd0, rd_data}, 32'h3C);
        @(negedge clk);
        check({req, " strobe one cycle"}, {30'd0, prog_stb, erase_stb}, 32'd0);
      end
      top_lock_n = 1'b1; main_lock_n = 1'b1;
    end

    // R9: program onto a non-erased byte
    tgt_rdata = 8'h00;
    run_seq(2'd0, 19'h01234, 8'h12);
    check("R9 not erased dropped", {31'd0, busy}, 32'd0);
    tgt_rdata = 8'hFF;

    // R4: whole-array opcode at the wrong address
    run_seq(2'd3, 19'h01234, 8'h00);
    check("R4 wrong address no start", {31'd0, busy}, 32'd0);

    // R5: a wrong step ends the sequence
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h11);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h01234, 8'h66);
    check("R5 aborted sequence", {31'd0, busy}, 32'd0);
    run_seq(2'd0, 19'h01234, 8'h66);
    check("R5 fresh sequence works", {31'd0, busy}, 32'd1);
    repeat (PC + 1) @(negedge clk);

    // R6: writes during busy ignored
    run_seq(2'd0, 19'h02000, 8'h77);
    run_seq(2'd1, 19'h30000, 8'h00);
    repeat (PC - 1 - 6) @(negedge clk);
    check("R6 busy unaffected", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R6 program strobe", {30'd0, prog_stb, erase_stb}, 32'd2);
    check("R6 op_data kept", {24'd0, op_data}, 32'h77);
    check("R6 op_addr kept", {13'd0, op_addr}, 32'h02000);
    @(negedge clk);
    check("R6 no later start", {31'd0, busy}, 32'd0);

    // R12: reset in the middle of an erase
    run_seq(2'd1, 19'h23000, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; #1;
    check("R12 busy dropped", {31'd0, busy}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < EC + 4; k++) begin
        @(negedge clk);
        if (prog_stb || erase_stb || busy) seen = 1'b1;
      end
      check("R12 no strobe after abort", {31'd0, seen}, 32'd0);
    end

    summary();
    $finish;
  end
endmodule